// File: doc/BRIEF.md
# Dual 32-bit General-Purpose Timer

The block holds two 32-bit up-counters, called low and high. Each has a compare register and a control word. The control word starts and stops the counter, picks what happens on a compare match, and picks what advances the counter. The counter can advance on every system clock cycle, on a divided system clock, on a slow real-time tick strobe, or on rising edges of an external event pin. When the counter reaches its compare value, the block emits a one-cycle interrupt pulse for that timer.

A cascade bit in the low timer's control word joins the two counters into a single 64-bit counter. In that mode the low timer's control word governs both halves. The high half advances when the low half rolls over. A match needs all 64 bits to agree, and only the high interrupt fires.

Software reaches the registers through a plain 32-bit write-strobe and read-address port. Read data is combinational from the address. The real-time tick is a single-cycle enable strobe that is already synchronous to the clock. The event pin is asynchronous.

Top module: `gpt_dual_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: With the run bit (control bit 0) set and source 0, the counter gains one per clock. A write that clears the run bit freezes the counter after that write's own clock edge.
- R3: Source 1 counts one tick every (P+1) clocks, where P is the 8-bit prescale field in control bits 15:8. A value of 0 ticks on every clock.
- R4: Source 2 counts each clock on which the tick strobe input is high.
- R5: Source 3 counts rising edges of the event pin after a two-flop synchroniser. Holding the pin high adds only one count.
- R6: Mode 0 (one-shot, control bits 2:1): the counter stops at the compare value, and the hardware clears the run bit on the match.
- R7: Mode 1 (continuous): the counter passes the compare value and wraps from all-ones to zero. Mode 3 behaves the same way.
- R8: Mode 2 (cycle): the counter returns to zero on the tick that would reach the compare value, so its period is the compare value in ticks.
- R9: Each match drives that timer's interrupt high for exactly the one cycle after the matching tick's edge.
- R10: Setting cascade (low control bit 6) makes {high,low} one 64-bit counter. It uses the low timer's run, source, mode and prescale, and ignores the high control word.
- R11: In cascade mode a match requires the 64-bit count to equal {high compare, low compare}. Only the high interrupt fires.
- R12: Writing the count register loads it, and this takes priority over a tick in the same cycle. Writing a control word with bit 5 set zeroes that counter (both halves in cascade). Bit 5 always reads 0.
- R13: Word address bit 2 selects the timer. Bits 1:0 select control (0), compare (1) or count (2). Other addresses read zero. Unused control bits and the high cascade bit read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick_i | input | 1 | Synchronous slow tick strobe |
| ext_evt_i | input | 1 | Asynchronous external event pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_lo_o | output | 1 | Low timer match pulse |
| irq_hi_o | output | 1 | High timer or 64-bit match pulse |

## Verification
A register write takes effect on the edge that captures it. The first clock-sourced tick lands on the following edge, so the count equals the number of edges seen after the starting write. An interrupt pulse is visible in the same cycle as the count update that caused it. The bench steps whole cycles from negative edge to negative edge and reads the combinational read port there. It counts interrupt pulses a quarter period after each rising edge, and it waits several cycles for event-pin edges, which arrive two to three edges late through the synchroniser. Expected counts come from bench functions that take the number of elapsed edges, the divider and the mode.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_AW = 3;

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_CMP  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;

  localparam int CB_RUN  = 0;
  localparam int CB_MODE = 1;
  localparam int CB_SRC  = 3;
  localparam int CB_CLR  = 5;
  localparam int CB_CASC = 6;
  localparam int CB_PSC  = 8;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_CONT    = 2'd1,
    MODE_CYCLE   = 2'd2,
    MODE_CONT2   = 2'd3
  } gpt_mode_e;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_PRESC = 2'd1,
    SRC_RTC   = 2'd2,
    SRC_EXT   = 2'd3
  } gpt_src_e;
endpackage

// File: rtl/gpt_sync_edge.sv
module gpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // rise seen between the last synchronised stage and its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         zero_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (zero_i) cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/gpt_dual_timer.sv
module gpt_dual_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick_i,
  input  logic              ext_evt_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int NT = 2;

  logic [NT-1:0]            run_q, wr_ctrl, wr_cmp, wr_cnt, clr;
  logic [NT-1:0]            src_hit, tick, hit, zero_req, stop_req, inc, zero, irq_q;
  logic [NT-1:0][1:0]       mode_q, src_q;
  logic [NT-1:0][PSC_W-1:0] psc_q;
  logic [NT-1:0][CNT_W-1:0] cmp_q, cnt_q, nxt;
  logic                     casc_q, ext_rise, lo_wrap, hit64;
  logic                     unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[CNT_W-1:CB_PSC+PSC_W], reg_wdata_i[CB_PSC-1]};

  gpt_sync_edge #(.STAGES(SYNC_STAGES)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_evt_i),
    .rise_o  (ext_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          casc_q <= 1'b0;
    else if (wr_ctrl[0]) casc_q <= reg_wdata_i[CB_CASC];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic psc_tick;
    logic addr_hit;

    assign addr_hit   = reg_wr_i && (reg_addr_i[REG_AW-1] == 1'(t));
    assign wr_ctrl[t] = addr_hit && (reg_addr_i[1:0] == FLD_CTRL);
    assign wr_cmp[t]  = addr_hit && (reg_addr_i[1:0] == FLD_CMP);
    assign wr_cnt[t]  = addr_hit && (reg_addr_i[1:0] == FLD_CNT);
    assign clr[t]     = wr_ctrl[t] && reg_wdata_i[CB_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[t]  <= 1'b0;
        mode_q[t] <= '0;
        src_q[t]  <= '0;
        psc_q[t]  <= '0;
      end else if (wr_ctrl[t]) begin
        run_q[t]  <= reg_wdata_i[CB_RUN];
        mode_q[t] <= reg_wdata_i[CB_MODE +: 2];
        src_q[t]  <= reg_wdata_i[CB_SRC +: 2];
        psc_q[t]  <= reg_wdata_i[CB_PSC +: PSC_W];
      end else if (stop_req[t]) begin
        run_q[t]  <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[t] <= '0;
      else if (wr_cmp[t]) cmp_q[t] <= reg_wdata_i;
    end

    gpt_prescaler #(.W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (run_q[t] && (src_q[t] == SRC_PRESC)),
      .div_i  (psc_q[t]),
      .tick_o (psc_tick)
    );

    always_comb begin
      unique case (src_q[t])
        SRC_SYS:   src_hit[t] = 1'b1;
        SRC_PRESC: src_hit[t] = psc_tick;
        SRC_RTC:   src_hit[t] = rtc_tick_i;
        default:   src_hit[t] = ext_rise;
      endcase
    end

    assign tick[t] = run_q[t] && src_hit[t];
    assign nxt[t]  = cnt_q[t] + CNT_W'(1);

    gpt_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_cnt[t]),
      .load_val_i (reg_wdata_i),
      .zero_i     (zero[t]),
      .inc_i      (inc[t]),
      .cnt_o      (cnt_q[t])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[t] <= 1'b0;
      else        irq_q[t] <= hit[t];
    end
  end

  // match, carry and mode actions for split and joined operation
  always_comb begin
    lo_wrap  = &cnt_q[0];
    hit64    = tick[0] &&
               ({(lo_wrap ? nxt[1] : cnt_q[1]), nxt[0]} == {cmp_q[1], cmp_q[0]});
    inc      = '0;
    hit      = '0;
    zero_req = '0;
    stop_req = '0;
    if (casc_q) begin
      inc[0]      = tick[0];
      inc[1]      = tick[0] && lo_wrap;
      hit[1]      = hit64;
      zero_req[0] = hit64 && (mode_q[0] == MODE_CYCLE);
      zero_req[1] = hit64 && (mode_q[0] == MODE_CYCLE);
      stop_req[0] = hit64 && (mode_q[0] == MODE_ONESHOT);
    end else begin
      for (int t = 0; t < NT; t++) begin
        inc[t]      = tick[t];
        hit[t]      = tick[t] && (nxt[t] == cmp_q[t]);
        zero_req[t] = hit[t] && (mode_q[t] == MODE_CYCLE);
        stop_req[t] = hit[t] && (mode_q[t] == MODE_ONESHOT);
      end
    end
    zero[0] = clr[0] || zero_req[0];
    zero[1] = clr[1] || zero_req[1] || (casc_q && clr[0]);
  end

  always_comb begin
    logic s;
    s           = reg_addr_i[REG_AW-1];
    reg_rdata_o = '0;
    unique case (reg_addr_i[1:0])
      FLD_CTRL: begin
        reg_rdata_o[CB_RUN]            = run_q[s];
        reg_rdata_o[CB_MODE +: 2]      = mode_q[s];
        reg_rdata_o[CB_SRC +: 2]       = src_q[s];
        reg_rdata_o[CB_CASC]           = !s && casc_q;
        reg_rdata_o[CB_PSC +: PSC_W]   = psc_q[s];
      end
      FLD_CMP: reg_rdata_o = cmp_q[s];
      FLD_CNT: reg_rdata_o = cnt_q[s];
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_lo_o = irq_q[0];
  assign irq_hi_o = irq_q[1];
endmodule

// File: rtl/gpt_dual_timer_chk.sv
module gpt_dual_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic             casc,
  input logic [1:0]       run,
  input logic [1:0]       mode_lo,
  input logic [1:0]       mode_hi,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi
);
  p_hold_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !reg_wr) |=> $stable(cnt_lo));

  p_hold_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[1] && !casc && !reg_wr) |=> $stable(cnt_hi));

  p_step_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + CNT_W'(1)
                        || cnt_lo == '0));

  p_step_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> (cnt_hi == $past(cnt_hi) || cnt_hi == $past(cnt_hi) + CNT_W'(1)
                        || cnt_hi == '0));

  p_oneshot_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !$past(reg_wr) && mode_lo == 2'd0) |-> !run[0]);

  p_oneshot_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && !$past(reg_wr) && !casc && mode_hi == 2'd0) |-> !run[1]);

  p_oneshot_casc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && !$past(reg_wr) && casc && mode_lo == 2'd0) |-> !run[0]);

  p_cycle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !$past(reg_wr) && mode_lo == 2'd2) |-> (cnt_lo == '0));

  p_lo_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(casc) |-> !irq_lo);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00) |=> (!irq_lo && !irq_hi));
endmodule

bind gpt_dual_timer gpt_dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr_i),
  .irq_lo  (irq_lo_o),
  .irq_hi  (irq_hi_o),
  .casc    (casc_q),
  .run     (run_q),
  .mode_lo (mode_q[0]),
  .mode_hi (mode_q[1]),
  .cnt_lo  (cnt_q[0]),
  .cnt_hi  (cnt_q[1])
);

// File: tb/sim_gpt_dual_timer.sv
module sim_gpt_dual_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, rtc = 1'b0, ext = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;
  int          n_cmp = 0, n_bad = 0, n_ilo = 0, n_ihi = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpt_dual_timer u0 (
    .clk (clk), .rst_n (rst_n), .rtc_tick_i (rtc), .ext_evt_i (ext),
    .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_lo_o (irq_lo), .irq_hi_o (irq_hi)
  );

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (irq_lo) n_ilo++;
    if (irq_hi) n_ihi++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int run, input int mode, input int src,
                                      input int clr, input int casc, input int psc);
    return 32'(run) | 32'(mode << 1) | 32'(src << 3) | 32'(clr << 5) |
           32'(casc << 6) | 32'(psc << 8);
  endfunction

  function automatic int ticks_of(input int n, input int src, input int psc);
    return (src == 0) ? n : n / (psc + 1);
  endfunction

  function automatic int exp_cnt(input int k, input int mode, input int cmp);
    if (mode == 0) return (k >= cmp) ? cmp : k;
    if (mode == 2) return k % cmp;
    return k;
  endfunction

  function automatic int exp_irq(input int k, input int mode, input int cmp);
    if (mode == 2) return k / cmp;
    return (k >= cmp) ? 1 : 0;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (d[i]) if (i < 8 && i != 3 && i != 7) begin
      rreg(3'(i), d); chk("R1", "reset reg", d, 32'h0);
      @(negedge clk);
    end
    chk("R1", "irq_lo at reset", {31'b0, irq_lo}, 32'h0);
    chk("R1", "irq_hi at reset", {31'b0, irq_hi}, 32'h0);

    // R13 readback and decode
    wreg(3'd5, 32'hDEAD_BEEF);
    wreg(3'd4, ctl(0, 2, 1, 1, 1, 8'hA5));
    rreg(3'd5, d); chk("R13", "cmp_hi readback", d, 32'hDEAD_BEEF);
    rreg(3'd4, d); chk("R13", "ctrl_hi readback", d, 32'h0000_A50C);
    rreg(3'd3, d); chk("R13", "unmapped read", d, 32'h0);
    wreg(3'd4, 32'h0);

    // R2 free count and freeze
    wreg(3'd1, 32'hFFFF_FFFF);
    wreg(3'd0, ctl(1, 1, 0, 1, 0, 0));
    idle(37);
    rreg(3'd2, d); chk("R2", "sysclk count", d, 32'd37);
    wreg(3'd0, ctl(0, 1, 0, 0, 0, 0));
    idle(10);
    rreg(3'd2, d); chk("R2", "frozen count", d, 32'd38);

    // R3 R6 R7 R8 R9 random runs
    for (int it = 0; it < 10; it++) begin
      int t, mode, src, psc, cmp, n, k;
      logic [2:0] base;
      t    = int'($urandom_range(0, 1));
      mode = int'($urandom_range(0, 2));
      src  = int'($urandom_range(0, 1));
      psc  = int'($urandom_range(0, 5));
      cmp  = int'($urandom_range(1, 40));
      n    = int'($urandom_range(1, 150));
      base = (t == 1) ? 3'd4 : 3'd0;
      wreg(base + 3'd1, 32'(cmp));
      wreg(base, ctl(1, mode, src, 1, 0, psc));
      n_ilo = 0; n_ihi = 0;
      idle(n);
      k = ticks_of(n, src, psc);
      rreg(base + 3'd2, d);
      chk(mode == 0 ? "R6" : (mode == 2 ? "R8" : "R3"), "random count", d,
          32'(exp_cnt(k, mode, cmp)));
      chk("R9", "random irq pulses", 32'((t == 1) ? n_ihi : n_ilo),
          32'(exp_irq(k, mode, cmp)));
      if (mode == 0) begin
        rreg(base, d);
        chk("R6", "one-shot run bit", {31'b0, d[0]}, (k >= cmp) ? 32'h0 : 32'h1);
      end
      wreg(base, 32'h0);
    end

    // R4 slow tick source
    wreg(3'd1, 32'hFFFF_FFFF);
    wreg(3'd0, ctl(1, 1, 2, 1, 0, 0));
    for (int p = 0; p < 7; p++) begin
      rtc = 1'b1; idle(1); rtc = 1'b0; idle(2);
    end
    rreg(3'd2, d); chk("R4", "tick strobe count", d, 32'd7);
    wreg(3'd0, 32'h0);

    // R5 external edges, level held
    wreg(3'd5, 32'hFFFF_FFFF);
    wreg(3'd4, ctl(1, 1, 3, 1, 0, 0));
    for (int p = 0; p < 4; p++) begin
      ext = 1'b1; idle(6); ext = 1'b0; idle(6);
    end
    rreg(3'd6, d); chk("R5", "event edge count", d, 32'd4);
    wreg(3'd4, 32'h0);

    // R7 wrap and pass compare
    wreg(3'd2, 32'hFFFF_FFFE);
    wreg(3'd1, 32'd5);
    wreg(3'd0, ctl(1, 1, 0, 0, 0, 0));
    n_ilo = 0;
    idle(3);
    rreg(3'd2, d); chk("R7", "wrap to one", d, 32'd1);
    idle(7);
    rreg(3'd2, d); chk("R7", "past compare", d, 32'd8);
    chk("R9", "single pulse continuous", 32'(n_ilo), 32'd1);

    // R12 load priority and clear
    wreg(3'd2, 32'h100);
    rreg(3'd2, d); chk("R12", "load beats tick", d, 32'h100);
    idle(4);
    rreg(3'd2, d); chk("R12", "count after load", d, 32'h104);
    wreg(3'd0, ctl(1, 1, 0, 1, 0, 0));
    rreg(3'd2, d); chk("R12", "clear zeroes", d, 32'h0);
    rreg(3'd0, d); chk("R12", "clear bit reads 0", d, 32'h3);
    wreg(3'd0, 32'h0);

    // R10 cascade, high control ignored
    wreg(3'd0, ctl(0, 1, 0, 0, 1, 0));
    wreg(3'd4, ctl(1, 1, 0, 0, 0, 0));
    wreg(3'd6, 32'd5);
    wreg(3'd2, 32'hFFFF_FFF0);
    wreg(3'd1, 32'd4);
    wreg(3'd5, 32'd6);
    wreg(3'd0, ctl(1, 1, 0, 0, 1, 0));
    n_ilo = 0; n_ihi = 0;
    idle(25);
    rreg(3'd2, d); chk("R10", "cascade low", d, 32'd9);
    rreg(3'd6, d); chk("R10", "cascade high carry", d, 32'd6);
    chk("R11", "cascade irq_hi", 32'(n_ihi), 32'd1);
    chk("R11", "cascade irq_lo silent", 32'(n_ilo), 32'd0);

    // R11 low half equal but high differs
    wreg(3'd0, ctl(0, 1, 0, 0, 1, 0));
    wreg(3'd2, 32'hFFFF_FFF0);
    wreg(3'd6, 32'd5);
    wreg(3'd5, 32'd9);
    wreg(3'd0, ctl(1, 1, 0, 0, 1, 0));
    n_ilo = 0; n_ihi = 0;
    idle(25);
    chk("R11", "partial match no irq", 32'(n_ihi + n_ilo), 32'd0);

    // R8 cascade cycle mode
    wreg(3'd0, ctl(0, 2, 0, 0, 1, 0));
    wreg(3'd2, 32'hFFFF_FFF0);
    wreg(3'd6, 32'd5);
    wreg(3'd5, 32'd6);
    wreg(3'd0, ctl(1, 2, 0, 0, 1, 0));
    n_ihi = 0;
    idle(25);
    rreg(3'd2, d); chk("R8", "cascade cycle low", d, 32'd5);
    rreg(3'd6, d); chk("R8", "cascade cycle high", d, 32'd0);
    chk("R9", "cascade cycle pulse", 32'(n_ihi), 32'd1);

    // R6 cascade one-shot
    wreg(3'd0, ctl(0, 0, 0, 0, 1, 0));
    wreg(3'd2, 32'hFFFF_FFF0);
    wreg(3'd6, 32'd5);
    wreg(3'd0, ctl(1, 0, 0, 0, 1, 0));
    idle(25);
    rreg(3'd2, d); chk("R6", "one-shot cascade low", d, 32'd4);
    rreg(3'd6, d); chk("R6", "one-shot cascade high", d, 32'd6);
    rreg(3'd0, d); chk("R6", "one-shot cascade run", {31'b0, d[0]}, 32'h0);
    wreg(3'd0, 32'h0);
    wreg(3'd4, 32'h0);

    idle(2);
    finish_up();
  end
endmodule